// File: doc/BRIEF.md
# Significand Alignment Right Shifter with Guard, Round and Sticky Output

This block prepares the operand with the smaller exponent for a floating-point addition. It takes that operand's significand, including the hidden bit, and a shift distance equal to the exponent difference. It returns the significand moved right by that many places. Three extra low-order positions are kept below the significand: guard, round and sticky. The sticky position collects every 1 bit that falls off the low end, so the rounding logic downstream still knows the shifted value was inexact.

The shift is built as a logarithmic barrel. Each stage either passes its input through or shifts it by a fixed power of two. A stage that shifts ORs the bits it pushes past the round position into the sticky position. The working width and the number of stages come from one fraction-length parameter through compile-time functions. For a 23-bit fraction the working width is 27 bits with 5 stages; for an 11-bit fraction it is 15 bits with 4 stages. A shift distance at or beyond the working width is detected and saturated. The result goes to one output register with a valid flag. The block has no state machine. Its one piece of state is the output register, which is either loaded (a valid input is present) or held.

Top module: `align_shifter`

## Requirements
- R1: The output is FRAC_W+4 bits wide. Bit FRAC_W+3 down to bit 3 hold the shifted significand, bit 2 is guard, bit 1 is round and bit 0 is sticky. The default FRAC_W=23 gives 27 bits.
- R2: For a shift distance k below the working width, bits W-1 down to 1 of the output equal bits W-1 down to 1 of ({significand, 3'b000} >> k).
- R3: For a shift distance k below the working width, the sticky bit is the OR of bits k down to 0 of {significand, 3'b000}.
- R4: For a shift distance at or above the working width, every output bit above bit 0 is zero, and the sticky bit is 1 exactly when the input significand is nonzero.
- R5: A shift distance of zero gives {significand, 3'b000}, with guard, round and sticky all zero.
- R6: The result appears on the clock edge after the one that samples a valid input. out_valid is high in a cycle exactly when in_valid was high one cycle earlier.
- R7: While in_valid is low the output register holds its previous value, whatever sig_in and shamt carry.
- R8: While rst_n is low, out_valid and every output bit are zero.
- R9: A nonzero significand never produces an all-zero output, for any shift distance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A significand and shift distance are present |
| sig_in | input | FRAC_W+1 | Significand with hidden bit in the top position |
| shamt | input | EXP_W | Right shift distance (exponent difference) |
| out_valid | output | 1 | aligned carries a fresh result |
| aligned | output | FRAC_W+4 | Shifted significand followed by guard, round and sticky |

## Verification
The checker verifies these on every cycle: valid timing, holding the register while idle, pass-through at zero shift, saturation at large distances, and the rule that nonzero input never collapses to zero. The exact placement of the guard and round bits for each intermediate distance is shown only by the bench. It sweeps every significand against every shift distance in a small configuration, compares the result with an arithmetic model, and adds directed edge distances on the 27-bit default build.

// File: rtl/align_pkg.sv
package align_pkg;

    // hidden bit + fraction + guard + round + sticky
    function automatic int work_width(input int frac_w);
        return frac_w + 4;
    endfunction

    // ceiling of log2, minimum 1
    function automatic int stage_count(input int width);
        int n;
        n = 0;
        while ((1 << n) < width) n++;
        if (n < 1) n = 1;
        return n;
    endfunction

endpackage

// File: rtl/align_stage.sv
module align_stage #(
    parameter int W  = 27,
    parameter int SH = 1
) (
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] moved;
    logic         lost_or;

    always_comb begin
        moved   = din >> SH;
        // positions SH..0 land on or below the sticky slot
        lost_or = |din[SH:0];
        if (en) dout = {moved[W-1:1], lost_or};
        else    dout = din;
    end
endmodule

// File: rtl/align_range_det.sv
module align_range_det #(
    parameter int EXP_W  = 8,
    parameter int WORK_W = 27
) (
    input  logic [EXP_W-1:0] shamt,
    output logic             over
);
    always_comb begin
        over = (32'(shamt) >= 32'(WORK_W));
    end
endmodule

// File: rtl/align_shifter.sv
module align_shifter
    import align_pkg::*;
#(
    parameter int FRAC_W = 23,
    parameter int EXP_W  = 8,
    localparam int SIG_W   = FRAC_W + 1,
    localparam int WORK_W  = work_width(FRAC_W),
    localparam int NSTAGES = stage_count(work_width(FRAC_W))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SIG_W-1:0]  sig_in,
    input  logic [EXP_W-1:0]  shamt,
    output logic              out_valid,
    output logic [WORK_W-1:0] aligned
);
    logic [WORK_W-1:0] chain [NSTAGES+1];
    logic [NSTAGES-1:0] sel;
    logic              over;
    logic [WORK_W-1:0] next_val;

    assign sel      = shamt[NSTAGES-1:0];
    assign chain[0] = {sig_in, 3'b000};

    genvar gi;
    generate
        for (gi = 0; gi < NSTAGES; gi++) begin : g_stage
            align_stage #(.W(WORK_W), .SH(1 << gi)) u_stage (
                .en  (sel[gi]),
                .din (chain[gi]),
                .dout(chain[gi+1])
            );
        end
    endgenerate

    align_range_det #(.EXP_W(EXP_W), .WORK_W(WORK_W)) u_range (
        .shamt(shamt),
        .over (over)
    );

    always_comb begin
        if (over) next_val = {{(WORK_W-1){1'b0}}, |sig_in};
        else      next_val = chain[NSTAGES];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            aligned   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) aligned <= next_val;
        end
    end
endmodule

// File: rtl/align_shifter_chk.sv
module align_shifter_chk #(
    parameter int SIG_W  = 24,
    parameter int EXP_W  = 8,
    parameter int WORK_W = 27
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [SIG_W-1:0]  sig_in,
    input logic [EXP_W-1:0]  shamt,
    input logic              out_valid,
    input logic [WORK_W-1:0] aligned
);
    // R6
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R6
    valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(aligned));
    // R5
    zero_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && shamt == '0) |=> aligned == {$past(sig_in), 3'b000});
    // R4
    saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && 32'(shamt) >= 32'(WORK_W)) |=>
        (aligned[WORK_W-1:1] == '0 && aligned[0] == |$past(sig_in)));
    // R9
    no_vanish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sig_in != '0) |=> aligned != '0);
endmodule

bind align_shifter align_shifter_chk #(
    .SIG_W (SIG_W),
    .EXP_W (EXP_W),
    .WORK_W(WORK_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .sig_in   (sig_in),
    .shamt    (shamt),
    .out_valid(out_valid),
    .aligned  (aligned)
);

// File: tb/tb_align_shifter.sv
module tb_align_shifter;
    localparam int CLK_PERIOD = 10;
    localparam int S_FRAC = 3;
    localparam int S_EXP  = 4;
    localparam int S_SIG  = S_FRAC + 1;
    localparam int S_W    = S_FRAC + 4;
    localparam int L_FRAC = 23;
    localparam int L_EXP  = 8;
    localparam int L_SIG  = L_FRAC + 1;
    localparam int L_W    = L_FRAC + 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic             s_iv = 1'b0;
    logic [S_SIG-1:0] s_sig = '0;
    logic [S_EXP-1:0] s_sh = '0;
    logic             s_ov;
    logic [S_W-1:0]   s_out;

    logic             l_iv = 1'b0;
    logic [L_SIG-1:0] l_sig = '0;
    logic [L_EXP-1:0] l_sh = '0;
    logic             l_ov;
    logic [L_W-1:0]   l_out;

    align_shifter #(.FRAC_W(S_FRAC), .EXP_W(S_EXP)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(s_iv), .sig_in(s_sig),
        .shamt(s_sh), .out_valid(s_ov), .aligned(s_out));

    align_shifter #(.FRAC_W(L_FRAC), .EXP_W(L_EXP)) dut_wide (
        .clk(clk), .rst_n(rst_n), .in_valid(l_iv), .sig_in(l_sig),
        .shamt(l_sh), .out_valid(l_ov), .aligned(l_out));

    int total = 0;
    int bad = 0;
    bit summary_done = 1'b0;

    function automatic logic [63:0] model(input logic [63:0] sig, input int sh, input int w);
        logic [63:0] ext, data, mask;
        logic st;
        ext = sig << 3;
        if (sh >= w) return {63'd0, |sig};
        data = ext >> sh;
        mask = (64'd1 << (sh + 1)) - 64'd1;
        st = |(ext & mask);
        return (data & ~64'd1) | {63'd0, st};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic run_small(input int sig, input int sh, input string req);
        @(negedge clk);
        s_iv = 1'b1; s_sig = S_SIG'(sig); s_sh = S_EXP'(sh);
        @(negedge clk);
        s_iv = 1'b0;
        check({req, " valid"}, {63'd0, s_ov}, 64'd1);
        check(req, {{(64-S_W){1'b0}}, s_out}, model(64'(sig), sh, S_W));
    endtask

    task automatic run_wide(input logic [L_SIG-1:0] sig, input int sh, input string req);
        @(negedge clk);
        l_iv = 1'b1; l_sig = sig; l_sh = L_EXP'(sh);
        @(negedge clk);
        l_iv = 1'b0;
        check(req, {{(64-L_W){1'b0}}, l_out}, model(64'(sig), sh, L_W));
    endtask

    task automatic finish_up;
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_up();
    end

    initial begin
        logic [S_W-1:0] held;
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 small valid", {63'd0, s_ov}, 64'd0);
        check("R8 small data", {57'd0, s_out}, 64'd0);
        check("R8 wide data", {37'd0, l_out}, 64'd0);
        rst_n = 1'b1;

        // R2 R3 R4 R5 R9: exhaustive small sweep
        for (int sg = 0; sg < (1 << S_SIG); sg++) begin
            for (int sh = 0; sh < (1 << S_EXP); sh++) begin
                run_small(sg, sh, sh == 0 ? "R5" : (sh >= S_W ? "R4" : "R2_R3"));
                if (sg != 0) check("R9", {63'd0, (s_out != '0)}, 64'd1);
            end
        end

        // R6 R7: idle cycle keeps data and drops valid
        run_small(13, 2, "R2");
        held = s_out;
        @(negedge clk);
        s_iv = 1'b0; s_sig = 4'h5; s_sh = 4'h0;
        @(negedge clk);
        check("R6 valid low", {63'd0, s_ov}, 64'd0);
        check("R7 hold", {57'd0, s_out}, {57'd0, held});

        // R1: default width 27, guard/round/sticky at bits 2..0
        run_wide(24'h800000, 0, "R1 R5");
        run_wide(24'h800000, 24, "R1 guard");
        run_wide(24'h800000, 25, "R1 round");
        run_wide(24'h800000, 26, "R1 sticky");
        run_wide(24'h800000, 27, "R4 edge");
        run_wide(24'h000001, 200, "R4 far");
        run_wide(24'h000000, 255, "R4 zero");
        run_wide(24'hFFFFFF, 1, "R2 R3");
        run_wide(24'hC00001, 3, "R3 sticky1");
        run_wide(24'hC00001, 4, "R3 sticky2");
        run_wide(24'hABCDEF, 13, "R2 mid");
        run_wide(24'h800001, 31, "R4 31");
        finish_up();
    end
endmodule